// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block sits between a host register bus and a byte-wide external EEPROM. The host does a single-byte read or write by loading an address register and a data register, then setting a request bit in a control register. The request bit clears itself once the operation finishes. When the host sees it at 0 after a read, the data register holds the fetched byte.

The block can also stream EEPROM content into device memory on its own. A burst walks the EEPROM from a start pointer that depends on history: EEPROM address 0 if no single access has happened since reset, otherwise the address just after the most recent byte access. The stream is a sequence of three-byte records: an address low byte, an address high byte, then a data byte. Each record produces one write to device memory. The memory address is a base register on top of the low 15 bits of the record address. A record address of 0xFFFF ends the burst.

Every EEPROM handshake is guarded by a programmable cycle limit. A stalled transfer is abandoned, its request bit is cleared, and a sticky timeout flag is set.

Top module: `eeprom_xfer_ctrl`

## Requirements
- R1: After reset, every register reads 0, except the limit register at offset 5, which reads its default of 1024. `ee_req` and `mem_valid` are low. Register offsets: 0 control, 1 address, 2 data, 3 burst start, 4 base, 5 limit, 6 status. A read of offset N appears on `reg_rdata` one clock after `reg_addr` is set to N.
- R2: Writing control bit 1 fetches the EEPROM byte at the address register into the data register. Control bit 1 then reads 0.
- R3: Writing control bit 0 stores the low byte of the data register at the address register's EEPROM location. Control bit 0 then reads 0.
- R4: Writing bit 0 of the burst-start register reads records of {address low, address high, data}. The burst issues one `mem_valid` pulse per record and never writes the EEPROM. It stops at a record address of 0xFFFF, and the burst bit then reads 0.
- R5: A burst started before any single access since reset begins at EEPROM address 0. A later burst begins one past the address of the last single access.
- R6: `mem_addr` is {base[8:0], record_address[14:0]}. Bit 15 of the record address is ignored.
- R7: A control or burst-start write made while an operation is in progress is discarded. It starts no extra EEPROM transfer and no burst.
- R8: A control write with bits 1 and 0 both set performs only the read. Control then reads 2'b10 while the read is pending.
- R9: If `ee_ack` has not come after `ee_req` has been high for the limit count of cycles, the request is dropped and the pending request or burst bit clears. Status bit 0 is then set, stays set through later successful operations, and clears when 1 is written to it.
- R10: `ee_addr`, `ee_we` and `ee_wdata` stay stable while `ee_req` waits for `ee_ack`. `ee_req` falls in the cycle after `ee_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset (write target and read select) |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | EEPROM one-cycle acknowledge |
| ee_rdata | input | 8 | Byte returned with the acknowledge |
| mem_valid | output | 1 | Device memory write strobe |
| mem_addr | output | 24 | Device memory byte address |
| mem_data | output | 8 | Device memory byte |

## Verification
The hardest situation to reach from the ports is a burst whose start pointer depends on history. The bench sets up both cases on purpose. It starts the first burst straight after reset, before any single access, and it starts a second burst immediately after a directed single read at 0x20. The EEPROM model holds records at 0 and at 0x21, so a wrong pointer produces visibly wrong memory writes. The model's acknowledge latency can also be stretched, which keeps an operation pending long enough for the bench to hit it with colliding requests. The model can withhold the acknowledge entirely to force both the single-access timeout and the burst timeout.

// File: rtl/eex_pkg.sv
package eex_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SINGLE, ST_BURST} eex_state_e;
  typedef enum logic [1:0] {REC_LO, REC_HI, REC_DATA} eex_rec_e;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_ADDR  = 1;
  localparam int OFS_DATA  = 2;
  localparam int OFS_BURST = 3;
  localparam int OFS_BASE  = 4;
  localparam int OFS_LIMIT = 5;
  localparam int OFS_STAT  = 6;
endpackage

// File: rtl/eex_port.sv
// One EEPROM byte transfer with an acknowledge-wait limit.
module eex_port #(
  parameter int AW   = 16,
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_we,
  input  logic [AW-1:0]   start_addr,
  input  logic [7:0]      start_wdata,
  input  logic [TO_W-1:0] limit,
  output logic            ee_req,
  output logic            ee_we,
  output logic [AW-1:0]   ee_addr,
  output logic [7:0]      ee_wdata,
  input  logic            ee_ack,
  input  logic [7:0]      ee_rdata,
  output logic            done,
  output logic            tmo,
  output logic [7:0]      rbyte
);
  logic [TO_W-1:0] wait_cnt;
  logic [TO_W:0]   next_cnt;

  assign next_cnt = {1'b0, wait_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_req   <= 1'b0;
      ee_we    <= 1'b0;
      ee_addr  <= '0;
      ee_wdata <= '0;
      wait_cnt <= '0;
      done     <= 1'b0;
      tmo      <= 1'b0;
      rbyte    <= '0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      if (!ee_req) begin
        wait_cnt <= '0;
        if (start) begin
          ee_req   <= 1'b1;
          ee_we    <= start_we;
          ee_addr  <= start_addr;
          ee_wdata <= start_wdata;
        end
      end else if (ee_ack) begin
        ee_req <= 1'b0;
        done   <= 1'b1;
        rbyte  <= ee_rdata;
      end else if (next_cnt >= {1'b0, limit}) begin
        ee_req <= 1'b0;
        tmo    <= 1'b1;
      end else begin
        wait_cnt <= next_cnt[TO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/eex_burst.sv
// Assembles three-byte burst records into device memory writes.
module eex_burst import eex_pkg::*; #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic [MEM_AW-EE_AW:0] base,
  output logic              more,
  output logic              fin,
  output logic              mem_valid,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  localparam int HI_W = EE_AW - 9;

  eex_rec_e        idx;
  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= REC_LO;
      lo_q      <= '0;
      hi_q      <= '0;
      more      <= 1'b0;
      fin       <= 1'b0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      more      <= 1'b0;
      fin       <= 1'b0;
      mem_valid <= 1'b0;
      if (clear) begin
        idx <= REC_LO;
      end else if (byte_valid) begin
        case (idx)
          REC_LO: begin
            lo_q <= byte_in;
            idx  <= REC_HI;
            more <= 1'b1;
          end
          REC_HI: begin
            hi_q <= byte_in[HI_W-1:0];
            if ({byte_in, lo_q} == {EE_AW{1'b1}}) begin
              idx <= REC_LO;
              fin <= 1'b1;
            end else begin
              idx  <= REC_DATA;
              more <= 1'b1;
            end
          end
          default: begin
            mem_valid <= 1'b1;
            mem_addr  <= {base, hi_q, lo_q};
            mem_data  <= byte_in;
            idx       <= REC_LO;
            more      <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_xfer_ctrl.sv
module eeprom_xfer_ctrl import eex_pkg::*; #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int TO_W   = 16,
  parameter int HW     = 16,
  parameter int RA_W   = 3,
  parameter logic [TO_W-1:0] TO_DEFAULT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [HW-1:0]     reg_wdata,
  output logic [HW-1:0]     reg_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_valid,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  localparam int BASE_W = MEM_AW - EE_AW + 1;

  eex_state_e       state;
  logic             rd_req, wr_req, burst_go, tmo_flag, kick;
  logic [EE_AW-1:0] addr_r, next_ptr;
  logic [7:0]       data_r;
  logic [BASE_W-1:0] base_r;
  logic [TO_W-1:0]  to_limit;
  logic             busy, burst_busy, host_ctrl, host_burst;
  logic             p_start, p_done, p_tmo, b_more, b_fin;
  logic [7:0]       p_rbyte;

  assign busy       = (state != ST_IDLE);
  assign burst_busy = (state == ST_BURST);
  assign host_ctrl  = reg_wr && (reg_addr == RA_W'(OFS_CTRL)) && !busy
                      && (reg_wdata[1] || reg_wdata[0]);
  assign host_burst = reg_wr && (reg_addr == RA_W'(OFS_BURST)) && !busy && reg_wdata[0];
  assign p_start    = kick || (burst_busy && b_more);

  eex_port #(.AW(EE_AW), .TO_W(TO_W)) u_port (
    .clk(clk), .rst(rst),
    .start(p_start),
    .start_we((state == ST_SINGLE) && wr_req),
    .start_addr(burst_busy ? next_ptr : addr_r),
    .start_wdata(data_r),
    .limit(to_limit),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .done(p_done), .tmo(p_tmo), .rbyte(p_rbyte)
  );

  eex_burst #(.EE_AW(EE_AW), .MEM_AW(MEM_AW)) u_burst (
    .clk(clk), .rst(rst),
    .clear(host_burst),
    .byte_valid(p_done && burst_busy),
    .byte_in(p_rbyte),
    .base(base_r),
    .more(b_more), .fin(b_fin),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      burst_go <= 1'b0;
      tmo_flag <= 1'b0;
      kick     <= 1'b0;
      addr_r   <= '0;
      next_ptr <= '0;
      data_r   <= '0;
      base_r   <= '0;
      to_limit <= TO_DEFAULT;
    end else begin
      kick <= host_ctrl || host_burst;
      if (reg_wr) begin
        case (reg_addr)
          RA_W'(OFS_ADDR):  addr_r   <= reg_wdata[EE_AW-1:0];
          RA_W'(OFS_DATA):  data_r   <= reg_wdata[7:0];
          RA_W'(OFS_BASE):  base_r   <= reg_wdata[BASE_W-1:0];
          RA_W'(OFS_LIMIT): to_limit <= reg_wdata[TO_W-1:0];
          RA_W'(OFS_STAT):  if (reg_wdata[0]) tmo_flag <= 1'b0;
          default: ;
        endcase
      end
      if (host_ctrl) begin
        state  <= ST_SINGLE;
        rd_req <= reg_wdata[1];
        wr_req <= !reg_wdata[1];
      end
      if (host_burst) begin
        state    <= ST_BURST;
        burst_go <= 1'b1;
      end
      if (p_done && (state == ST_SINGLE)) begin
        if (rd_req) data_r <= p_rbyte;
        rd_req   <= 1'b0;
        wr_req   <= 1'b0;
        next_ptr <= addr_r + 1'b1;
        state    <= ST_IDLE;
      end
      if (p_done && burst_busy) next_ptr <= next_ptr + 1'b1;
      if (b_fin) begin
        burst_go <= 1'b0;
        state    <= ST_IDLE;
      end
      if (p_tmo) begin
        rd_req   <= 1'b0;
        wr_req   <= 1'b0;
        burst_go <= 1'b0;
        tmo_flag <= 1'b1;
        state    <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_W'(OFS_CTRL):  reg_rdata <= HW'({rd_req, wr_req});
        RA_W'(OFS_ADDR):  reg_rdata <= HW'(addr_r);
        RA_W'(OFS_DATA):  reg_rdata <= HW'(data_r);
        RA_W'(OFS_BURST): reg_rdata <= HW'(burst_go);
        RA_W'(OFS_BASE):  reg_rdata <= HW'(base_r);
        RA_W'(OFS_LIMIT): reg_rdata <= HW'(to_limit);
        RA_W'(OFS_STAT):  reg_rdata <= HW'(tmo_flag);
        default:          reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/eex_checker.sv
module eex_checker #(
  parameter int EE_AW = 16,
  parameter int TO_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ee_req,
  input logic             ee_ack,
  input logic             ee_we,
  input logic [EE_AW-1:0] ee_addr,
  input logic [7:0]       ee_wdata,
  input logic             mem_valid,
  input logic             burst_busy,
  input logic [TO_W-1:0]  to_limit
);
  logic [TO_W:0] req_run;

  always_ff @(posedge clk) begin
    if (rst || !ee_req) req_run <= '0;
    else                req_run <= req_run + 1'b1;
  end

  // R9: a request never waits longer than the programmed limit
  p_req_window_r9: assert property (@(posedge clk) disable iff (rst)
    (ee_req && (to_limit != '0)) |-> (req_run < {1'b0, to_limit}));

  // R10: request fields hold while waiting
  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (ee_req && !ee_ack) |=> (!ee_req || ($stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata))));

  // R10: acknowledge ends the request
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (ee_req && ee_ack) |=> !ee_req);

  // R4: one memory write per record, never back to back
  p_mem_single_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> !mem_valid);

  // R4: bursts only read the EEPROM
  p_burst_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    (ee_req && burst_busy) |-> !ee_we);
endmodule

bind eeprom_xfer_ctrl eex_checker #(.EE_AW(EE_AW), .TO_W(TO_W)) u_eex_checker (
  .clk(clk), .rst(rst), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_wdata(ee_wdata), .mem_valid(mem_valid),
  .burst_busy(burst_busy), .to_limit(to_limit)
);

// File: tb/eeprom_xfer_ctrl_bench.sv
module eeprom_xfer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {op (1 = write), address, data}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 16'h0040, 8'hC3}, {1'b0, 16'h0040, 8'h00},
    {1'b0, 16'h0041, 8'h00}, {1'b1, 16'h007F, 8'h00},
    {1'b0, 16'h007F, 8'h00}, {1'b1, 16'h0090, 8'hFF},
    {1'b0, 16'h0090, 8'h00}, {1'b0, 16'h00A7, 8'h00}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        ee_req, ee_we, ee_ack;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata;
  logic        mem_valid;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;

  int n_chk = 0, n_bad = 0;
  int lat = 0;
  logic mute = 1'b0;
  int txn = 0, req_cycles = 0, wait_cnt = 0;
  logic [7:0]  mdl [256];
  logic [7:0]  exp_mem [256];
  logic [23:0] log_addr [16];
  logic [7:0]  log_data [16];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_xfer_ctrl u_eeprom_xfer_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  function automatic logic [7:0] init_byte(int i);
    case (i)
      0: return 8'h12;  1: return 8'h00;  2: return 8'hA1;
      3: return 8'h34;  4: return 8'h80;  5: return 8'hB2;
      6, 7: return 8'hFF;
      8'h21: return 8'h00; 8'h22: return 8'h01; 8'h23: return 8'h77;
      8'h24, 8'h25: return 8'hFF;
      default: return 8'(i) ^ 8'h5A;
    endcase
  endfunction

  // EEPROM model: acknowledges after lat waiting cycles unless muted
  always @(posedge clk) begin
    if (rst) begin
      ee_ack <= 1'b0;
      ee_rdata <= '0;
      wait_cnt <= 0;
      for (int i = 0; i < 256; i++) mdl[i] <= init_byte(i);
    end else if (ee_req && !ee_ack && !mute) begin
      if (wait_cnt >= lat) begin
        ee_ack <= 1'b1;
        ee_rdata <= mdl[ee_addr[7:0]];
        if (ee_we) mdl[ee_addr[7:0]] <= ee_wdata;
        wait_cnt <= 0;
        txn <= txn + 1;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      ee_ack <= 1'b0;
    end
    if (!rst && ee_req) req_cycles <= req_cycles + 1;
    if (!rst && mem_valid && log_n < 16) begin
      log_addr[log_n] <= mem_addr;
      log_data[log_n] <= mem_data;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input int ofs, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(ofs); reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input int ofs, output logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'(ofs);
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic wait_zero(input int ofs);
    logic [15:0] v;
    for (int k = 0; k < 3000; k++) begin
      rreg(ofs, v);
      if (v == 16'h0) break;
    end
  endtask

  task automatic single(input logic we, input logic [15:0] a, input logic [7:0] d);
    wreg(1, a);
    if (we) begin wreg(2, {8'h0, d}); exp_mem[a[7:0]] = d; end
    wreg(0, we ? 16'h1 : 16'h2);
    wait_zero(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t0, n0;
    for (int i = 0; i < 256; i++) exp_mem[i] = init_byte(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 ee_req", 32'(ee_req), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    for (int o = 0; o < 7; o++) begin
      rreg(o, v);
      chk("R1 register", 32'(v), (o == 5) ? 32'd1024 : 32'd0);
    end

    // R5/R4/R6: first burst right after reset starts at address 0
    wreg(4, 16'h01A5);
    wreg(3, 16'h1);
    wait_zero(3);
    chk("R4 burst records", log_n, 2);
    chk("R6 rec0 addr", 32'(log_addr[0]), 32'({9'h1A5, 15'h0012}));
    chk("R5 rec0 data", 32'(log_data[0]), 32'hA1);
    chk("R6 top bit ignored", 32'(log_addr[1]), 32'({9'h1A5, 15'h0034}));
    chk("R4 rec1 data", 32'(log_data[1]), 32'hB2);

    // R2/R3: vector table
    for (int i = 0; i < NVEC; i++) begin
      single(VEC[i][24], VEC[i][23:8], VEC[i][7:0]);
      rreg(0, v);
      chk(VEC[i][24] ? "R3 ctrl cleared" : "R2 ctrl cleared", 32'(v), 0);
      if (VEC[i][24]) begin
        chk("R3 eeprom byte", 32'(mdl[VEC[i][15:8]]), 32'(VEC[i][7:0]));
      end else begin
        rreg(2, v);
        chk("R2 read data", 32'(v), 32'(exp_mem[VEC[i][15:8]]));
      end
    end

    // R5: burst resumes after last single access (0x20 -> 0x21)
    single(1'b0, 16'h0020, 8'h00);
    wreg(4, 16'h0003);
    n0 = log_n;
    wreg(3, 16'h1);
    wait_zero(3);
    chk("R5 resumed burst count", log_n - n0, 1);
    chk("R5 resumed addr", 32'(log_addr[n0]), 32'({9'h003, 15'h0100}));
    chk("R5 resumed data", 32'(log_data[n0]), 32'h77);

    // R7: requests during a pending read are dropped
    lat = 20;
    t0 = txn; n0 = log_n;
    wreg(1, 16'h0055);
    wreg(2, 16'h00EE);
    wreg(0, 16'h2);
    wreg(0, 16'h1);
    wreg(3, 16'h1);
    wait_zero(0);
    repeat (40) @(negedge clk);
    chk("R7 one transfer", txn - t0, 1);
    rreg(3, v);
    chk("R7 burst bit", 32'(v), 0);
    chk("R7 no memory writes", log_n - n0, 0);
    chk("R7 eeprom unchanged", 32'(mdl[8'h55]), 32'(exp_mem[8'h55]));

    // R8: read wins over write
    wreg(1, 16'h0066);
    wreg(2, 16'h00EE);
    wreg(0, 16'h3);
    rreg(0, v);
    chk("R8 ctrl pending", 32'(v), 32'h2);
    wait_zero(0);
    rreg(2, v);
    chk("R8 read data", 32'(v), 32'(exp_mem[8'h66]));
    chk("R8 eeprom unchanged", 32'(mdl[8'h66]), 32'(exp_mem[8'h66]));
    lat = 0;

    // R9: timeout on a single read
    mute = 1'b1;
    wreg(5, 16'd8);
    @(negedge clk);
    req_cycles = 0;
    wreg(1, 16'h0044);
    wreg(0, 16'h2);
    wait_zero(0);
    chk("R9 req cycles", req_cycles, 8);
    rreg(6, v);
    chk("R9 flag set", 32'(v), 1);
    mute = 1'b0;
    single(1'b0, 16'h0044, 8'h00);
    rreg(6, v);
    chk("R9 flag sticky", 32'(v), 1);
    wreg(6, 16'h1);
    rreg(6, v);
    chk("R9 flag cleared", 32'(v), 0);

    // R9: timeout during a burst
    mute = 1'b1;
    n0 = log_n;
    wreg(3, 16'h1);
    wait_zero(3);
    rreg(3, v);
    chk("R9 burst bit cleared", 32'(v), 0);
    rreg(6, v);
    chk("R9 burst flag", 32'(v), 1);
    chk("R9 burst no writes", log_n - n0, 0);
    mute = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule